// File: doc/BRIEF.md
# H-Bridge Gate Command Decoder with Crossover Dead Time

This block sits between the control bits of one DC-motor full bridge and its four gate drivers. It takes a direction bit, an enable bit, a decay-select bit and a chop request from the current regulator, and turns them into the on/off commands for the high and low switch of each leg (leg A and leg B). When the bridge is enabled and not chopping, it drives the load in the chosen direction. Otherwise it lets the current decay, in one of two ways. Slow decay turns on both low-side switches. Fast decay reverses the diagonal, so the winding current flows back into the supply. In both decay styles the decay path runs through switches that are turned on, not through body diodes.

A zero-current flag from an external detector stops fast decay before the load current reverses. When the flag arrives during fast decay, the block opens all four switches and keeps them open until the decoded command changes. Whenever a leg swaps between its high and its low switch, both switches of that leg stay off for a configurable number of clock cycles. This prevents shoot-through. A kill input switches all gates off in the same cycle, without waiting for a clock edge.

Top module: `hbridge_gate_decoder`

## Requirements
- R1: With `enable`=1 and `chop`=0, `phase`=1 settles to leg A high and leg B low, and `phase`=0 settles to leg A low and leg B high. `decay_slow` has no effect in this case.
- R2: When the bridge is not driving (`enable`=0, or `chop`=1) and `decay_slow`=1, both legs settle low (`gate_al`=`gate_bl`=1, both highs off), whatever `phase` is.
- R3: When the bridge is not driving and `decay_slow`=0, each leg settles to the opposite of its drive level. `phase`=1 gives leg A low and leg B high. `phase`=0 gives leg A high and leg B low.
- R4: A chop request with `enable`=1 decodes exactly as `enable`=0 with the same `decay_slow` and `phase`.
- R5: If `zero_cur` is 1 on an edge while fast decay is decoded, the hold flag sets on that edge. From the following edge on, all four gates are off. The hold is kept while the decoded command stays the same, even if `zero_cur` returns to 0. It clears on the first edge at which the decoded command changes. In slow decay and in drive, `zero_cur` has no effect.
- R6: A leg whose target level changes leaves its old switch off on the next edge. It then stays with both switches off for exactly DEAD_CYC cycles before the new switch turns on. A leg whose target does not change keeps its gates. A leg that is off with its timer expired turns on at the first edge after its target appears.
- R7: The high and low gate of one leg are never 1 at the same time, and no gate goes from high to low of the same leg on consecutive cycles.
- R8: While `kill`=1, all four gates are 0 in the same cycle. Kill also clears the zero-current hold. After `kill` falls, each leg waits a full DEAD_CYC cycles with both switches off before turning on.
- R9: During and right after reset, all four gates are 0. The first target after reset appears one edge later, with no dead-time wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phase | input | 1 | Direction select (1 = leg A sources) |
| enable | input | 1 | 1 = drive, 0 = decay |
| decay_slow | input | 1 | 1 = slow decay, 0 = fast decay |
| chop | input | 1 | Current-limit off-time request |
| zero_cur | input | 1 | Load current near zero |
| kill | input | 1 | Forces all gates off at once |
| gate_ah | output | 1 | Leg A high-side gate command |
| gate_al | output | 1 | Leg A low-side gate command |
| gate_bh | output | 1 | Leg B high-side gate command |
| gate_bl | output | 1 | Leg B low-side gate command |

## Verification
The bench builds the decoder with DEAD_CYC=4. This keeps each crossover window short, so that thousands of command changes fit in one run, and it lets changes arrive in the middle of a dead-time window, in the middle of a zero-current hold, and just after a kill is released. Directed phases cover every row of the decode: drive in both directions, slow and fast decay, chop with enable high, the zero-current hold and its release, and zero-current pulses in slow decay and drive, where they must have no effect. A long random phase then mixes all inputs. Each cycle is compared against a behavioural reference of the leg timers and the hold flag.

// File: rtl/hbridge_gate_decoder.sv
module hbridge_gate_decoder #(
  parameter int DEAD_CYC = 22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic phase,
  input  logic enable,
  input  logic decay_slow,
  input  logic chop,
  input  logic zero_cur,
  input  logic kill,
  output logic gate_ah,
  output logic gate_al,
  output logic gate_bh,
  output logic gate_bl
);
  localparam int CW = $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] RELOAD = CW'(DEAD_CYC - 1);

  typedef enum logic [1:0] {LV_OFF, LV_HI, LV_LO} lvl_t;

  logic drive, fast;
  logic [2:0] cmd, cmd_q;
  logic hold_q;
  lvl_t tgt [2];
  lvl_t cur [2];
  logic [CW-1:0] cnt [2];

  assign drive = enable & ~chop;
  assign fast  = ~drive & ~decay_slow;
  assign cmd   = {drive, ~drive & decay_slow, (drive | ~decay_slow) & phase};

  always_comb begin
    if (hold_q) begin
      tgt[0] = LV_OFF;
      tgt[1] = LV_OFF;
    end else if (drive) begin
      tgt[0] = phase ? LV_HI : LV_LO;
      tgt[1] = phase ? LV_LO : LV_HI;
    end else if (decay_slow) begin
      tgt[0] = LV_LO;
      tgt[1] = LV_LO;
    end else begin
      tgt[0] = phase ? LV_LO : LV_HI;
      tgt[1] = phase ? LV_HI : LV_LO;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      cmd_q  <= cmd;
      hold_q <= ~kill & fast & (zero_cur | (hold_q & (cmd == cmd_q)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        cur[i] <= LV_OFF;
        cnt[i] <= '0;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (kill) begin
          cur[i] <= LV_OFF;
          cnt[i] <= RELOAD;
        end else if (tgt[i] != cur[i]) begin
          if (cur[i] != LV_OFF) begin
            cur[i] <= LV_OFF;
            cnt[i] <= RELOAD;
          end else if (cnt[i] == '0) begin
            cur[i] <= tgt[i];
          end else begin
            cnt[i] <= cnt[i] - 1'b1;
          end
        end else if (cnt[i] != '0) begin
          cnt[i] <= cnt[i] - 1'b1;
        end
      end
    end
  end

  assign gate_ah = ~kill & (cur[0] == LV_HI);
  assign gate_al = ~kill & (cur[0] == LV_LO);
  assign gate_bh = ~kill & (cur[1] == LV_HI);
  assign gate_bl = ~kill & (cur[1] == LV_LO);

  p_leg_a_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_ah && gate_al));
  p_leg_b_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_bh && gate_bl));
  p_kill_all_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    kill |-> !(gate_ah || gate_al || gate_bh || gate_bl));
  p_a_hi_no_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gate_ah |=> !gate_al);
  p_a_lo_no_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gate_al |=> !gate_ah);
  p_b_hi_no_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gate_bh |=> !gate_bl);
  p_b_lo_no_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gate_bl |=> !gate_bh);
  p_hold_blocks_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !kill && cmd == cmd_q && $stable(cmd)) |=> !(gate_ah || gate_al || gate_bh || gate_bl));
endmodule

// File: tb/hbridge_gate_decoder_bench.sv
module hbridge_gate_decoder_bench;
  localparam int DEAD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phase = 1'b0, enable = 1'b0, decay_slow = 1'b0, chop = 1'b0, zero_cur = 1'b0, kill = 1'b0;
  logic gate_ah, gate_al, gate_bh, gate_bl;

  int vectors = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  // reference: level 0 = off, 1 = high, 2 = low
  int lv [2];
  int tmr [2];
  bit hz;
  int pkey;

  always #2.5 clk = ~clk;

  hbridge_gate_decoder #(.DEAD_CYC(DEAD)) u_hbridge_gate_decoder (
    .clk(clk), .rst_n(rst_n), .phase(phase), .enable(enable),
    .decay_slow(decay_slow), .chop(chop), .zero_cur(zero_cur), .kill(kill),
    .gate_ah(gate_ah), .gate_al(gate_al), .gate_bh(gate_bh), .gate_bl(gate_bl));

  function automatic int ref_key();
    bit drv = enable && !chop;
    if (drv) return phase ? 1 : 0;
    if (decay_slow) return 2;
    return phase ? 4 : 3;
  endfunction

  task automatic ref_step();
    int k = ref_key();
    int want [2];
    bit nhz;
    case (k)
      0: begin want[0] = 2; want[1] = 1; end
      1: begin want[0] = 1; want[1] = 2; end
      2: begin want[0] = 2; want[1] = 2; end
      3: begin want[0] = 1; want[1] = 2; end
      default: begin want[0] = 2; want[1] = 1; end
    endcase
    if (hz) begin want[0] = 0; want[1] = 0; end
    nhz = !kill && k >= 3 && (zero_cur || (hz && k == pkey));
    for (int i = 0; i < 2; i++) begin
      if (kill) begin lv[i] = 0; tmr[i] = DEAD - 1; end
      else if (want[i] != lv[i]) begin
        if (lv[i] != 0) begin lv[i] = 0; tmr[i] = DEAD - 1; end
        else if (tmr[i] == 0) lv[i] = want[i];
        else tmr[i]--;
      end else if (tmr[i] > 0) tmr[i]--;
    end
    hz = nhz;
    pkey = k;
  endtask

  function automatic string tag_now();
    int k = ref_key();
    if (!rst_n) return "R9";
    if (kill) return "R8";
    if (hz) return "R5";
    if (tmr[0] > 0 || tmr[1] > 0) return "R6";
    if (k <= 1) return "R1";
    if (enable && chop) return "R4";
    if (k == 2) return "R2";
    return "R3";
  endfunction

  task automatic compare();
    logic [3:0] got, exp;
    got = {gate_ah, gate_al, gate_bh, gate_bl};
    exp = {!kill && lv[0] == 1, !kill && lv[0] == 2, !kill && lv[1] == 1, !kill && lv[1] == 2};
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: gates(ah,al,bh,bl)=%b expected=%b", tag_now(), cycles, got, exp);
    end
    if ((gate_ah && gate_al) || (gate_bh && gate_bl)) begin
      errors++;
      $display("FAIL R7 cycle %0d: shoot-through gates=%b expected no leg with both on", cycles, got);
    end
  endtask

  task automatic step(input bit ph, input bit en, input bit md, input bit ch,
                      input bit zc, input bit kl, input int n);
    for (int j = 0; j < n; j++) begin
      phase = ph; enable = en; decay_slow = md; chop = ch; zero_cur = zc; kill = kl;
      @(posedge clk);
      cycles++;
      ref_step();
      @(negedge clk);
      compare();
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin lv[i] = 0; tmr[i] = 0; end
    hz = 1'b0; pkey = 3;
    repeat (3) @(negedge clk);
    compare(); // R9 reset state
    rst_n = 1'b1;
    // R9 first target after reset, R1 forward drive under both decay selects
    step(1, 1, 1, 0, 0, 0, 6);
    step(1, 1, 0, 0, 0, 0, 6);
    // R1 reverse drive with crossover on both legs (R6)
    step(0, 1, 0, 0, 0, 0, 10);
    step(0, 1, 1, 0, 0, 0, 4);
    // R2 brake, phase ignored
    step(0, 0, 1, 0, 0, 0, 8);
    step(1, 0, 1, 0, 0, 0, 8);
    // R5 zero flag ignored in slow decay and in drive
    step(1, 0, 1, 0, 1, 0, 4);
    step(1, 1, 0, 0, 1, 0, 8);
    // R3 fast decay from forward, then zero flag hold
    step(1, 0, 0, 0, 0, 0, 10);
    step(1, 0, 0, 0, 1, 0, 1);
    step(1, 0, 0, 0, 0, 0, 8);
    // R5 hold released by a command change (drive resumes)
    step(1, 1, 0, 0, 0, 0, 8);
    // R3 fast decay from reverse
    step(0, 0, 0, 0, 0, 0, 10);
    // R4 chop with enable high, both decay selects
    step(1, 1, 1, 0, 0, 0, 8);
    step(1, 1, 1, 1, 0, 0, 8);
    step(1, 1, 0, 1, 0, 0, 10);
    step(1, 1, 0, 1, 1, 0, 3);
    step(0, 1, 0, 1, 0, 0, 8);
    // R6 target change inside a dead-time window
    step(1, 1, 0, 0, 0, 0, 2);
    step(0, 1, 0, 0, 0, 0, 2);
    step(1, 1, 0, 0, 0, 0, 8);
    // R8 kill in drive, release
    step(1, 1, 0, 0, 0, 0, 2);
    step(1, 1, 0, 0, 0, 1, 3);
    step(1, 1, 0, 0, 0, 0, 8);
    // mixed random traffic across all requirements
    for (int r = 0; r < 3000; r++) begin
      int hold = 1 + ($urandom % 6);
      step($urandom % 2, ($urandom % 4) != 0, $urandom % 2, ($urandom % 5) == 0,
           ($urandom % 6) == 0, ($urandom % 40) == 0, hold);
    end
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      finish_run();
    end
  end
endmodule